// File: doc/BRIEF.md
# Scatter-Gather Segment Walker

This block turns one data pointer and a parcel byte count into the ordered list of memory segments that make up the parcel. When the pointer's indirect flag is clear, the parcel is contiguous. The walker then emits a single segment at the pointer address, whose length is the whole parcel, and it reads no memory. When the flag is set, the pointer addresses a chain of link tables. The walker fetches 64-bit entries through a simple read request/response port and emits one address/length segment per regular entry. It jumps to a new table whenever it meets a continuation entry.

Every walk ends with a one-cycle `done` pulse that carries an error code. A mode input taken at start decides whether a failed walk raises the gather error flag or the scatter error flag. The walker checks each entry against the running byte total. It stops at the first malformed entry, at the first overrun of the parcel length, or at a final entry that leaves the total short or long.

Top module: `sg_walker`

## Requirements
- R1: While `rst_n` is low, `seg_valid`, `rd_req_valid`, `done`, `gather_err` and `scatter_err` are 0.
- R2: A start with `ptr_indirect`=0 and a nonzero `parcel_len` emits exactly one segment with `seg_addr`=`ptr_addr`, `seg_len`=`parcel_len` and `seg_last`=1. It issues no read, and `done` then reports `err_code` 0. If `parcel_len` is 0, no segment is emitted and `err_code` is 1.
- R3: A start with `ptr_indirect`=1 issues its first read at `ptr_addr`. Each following entry of the same table is read at the previous entry address plus 8.
- R4: A regular entry has bit 40 at 0. Bits 63:48 hold the length and bits 35:0 hold the address. A regular entry with a nonzero length emits one segment with that address and length. `seg_last` is 1 only when bit 41 of that entry is 1.
- R5: An entry with bit 40 at 1 and length 0 emits no segment. The next read goes to the address in bits 35:0 of that entry, and bit 41 of that entry has no effect.
- R6: A regular entry with length 0 ends the walk with no segment for it, and `err_code` is 1.
- R7: An entry with bit 40 at 1 and a nonzero length ends the walk with no further read, and `err_code` is 2.
- R8: A regular entry with bit 41 at 1 whose length brings the running total to a value other than `parcel_len` emits no segment. The walk ends with `err_code` 3.
- R9: A regular entry with bit 41 at 0 whose length makes the running total exceed `parcel_len` emits no segment and is followed by no read. The walk ends with `err_code` 4.
- R10: While `seg_valid` is 1 and `seg_ready` is 0, the segment outputs stay unchanged. While `rd_req_valid` is 1 and `rd_req_ready` is 0, `rd_req_addr` stays unchanged.
- R11: `done` pulses for one cycle per walk. When `err_code` is nonzero, `gather_err` (mode 0) or `scatter_err` (mode 1) pulses with it. Neither flag is raised on a clean walk, and the two flags are never raised together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| ptr_addr | input | 36 | Parcel or first link entry address |
| ptr_indirect | input | 1 | 1: pointer addresses a link table |
| parcel_len | input | 16 | Total parcel byte count |
| scatter_mode | input | 1 | 0: report as gather, 1: report as scatter |
| rd_req_valid | output | 1 | Entry read request |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 36 | Entry address to read |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | 64 | Link table entry |
| seg_valid | output | 1 | Segment available |
| seg_ready | input | 1 | Segment consumed |
| seg_addr | output | 36 | Segment start address |
| seg_len | output | 16 | Segment byte count |
| seg_last | output | 1 | Final segment of the parcel |
| done | output | 1 | One-cycle end-of-walk pulse |
| err_code | output | 3 | 0 ok, 1 zero length, 2 bad continuation, 3 final total mismatch, 4 overrun |
| gather_err | output | 1 | Error pulse in gather mode |
| scatter_err | output | 1 | Error pulse in scatter mode |

## Verification
A wrong running total shows up as a false code 3 or 4, or as a missing one, on the `done` pulse that ends the very walk where it went wrong. It also changes how many segments and reads the walk produced. A bad fetch address appears on `rd_req_addr` at the next request, one cycle after a segment is accepted or a continuation entry returns. A state machine stuck in the emit or wait state shows as `done` never arriving, which the per-walk timeouts catch.

// File: rtl/sg_pkg.sv
// Shared types for the scatter-gather segment walker.
// Assumes link entries are 64 bits with the field positions below.
package sg_pkg;
    localparam int ENTRY_W   = 64;
    localparam int LEN_HI    = 63;
    localparam int LEN_LO    = 48;
    localparam int RET_BIT   = 41;
    localparam int CONT_BIT  = 40;
    localparam int ENTRY_ADR = 36;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_ZERO_LEN = 3'd1,
        ERR_CONT_LEN = 3'd2,
        ERR_MISMATCH = 3'd3,
        ERR_OVERRUN  = 3'd4
    } sg_err_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_REQ, ST_WAIT, ST_EMIT, ST_DONE
    } sg_state_e;
endpackage

// File: rtl/sg_entry_decode.sv
// Classifies one fetched link entry against the running byte total.
// Purely combinational; assumes acc never exceeds plen on entry.
module sg_entry_decode #(
    parameter int ADDR_W = 36,
    parameter int LEN_W  = 16,
    localparam int ACC_W = LEN_W + 1
) (
    input  logic [sg_pkg::ENTRY_W-1:0] entry,
    input  logic [ACC_W-1:0]           acc,
    input  logic [LEN_W-1:0]           plen,
    output logic [ADDR_W-1:0]          ent_addr,
    output logic [LEN_W-1:0]           ent_len,
    output logic                       ent_final,
    output logic                       ent_cont,
    output logic [ACC_W-1:0]           acc_next,
    output sg_pkg::sg_err_e            ent_err
);
    import sg_pkg::*;

    logic rsvd_unused;

    // Field extraction
    always_comb begin
        ent_len     = entry[LEN_HI:LEN_LO];
        ent_final   = entry[RET_BIT];
        ent_cont    = entry[CONT_BIT];
        ent_addr    = entry[ADDR_W-1:0];
        rsvd_unused = ^{entry[LEN_LO-1:RET_BIT+1], entry[CONT_BIT-1:ADDR_W]};
        acc_next    = acc + ACC_W'(ent_len);
    end

    // Error classification in priority order
    always_comb begin
        ent_err = ERR_NONE;
        if (ent_cont) begin
            if (ent_len != '0) ent_err = ERR_CONT_LEN;
        end else if (ent_len == '0) begin
            ent_err = ERR_ZERO_LEN;
        end else if (ent_final) begin
            if (acc_next != ACC_W'(plen)) ent_err = ERR_MISMATCH;
        end else if (acc_next > ACC_W'(plen)) begin
            ent_err = ERR_OVERRUN;
        end
    end
endmodule

// File: rtl/sg_len_accum.sv
// Running byte total of segments emitted in the current walk.
// Cleared at walk start, loaded with the decoder's sum on each accepted entry.
module sg_len_accum #(
    parameter int LEN_W  = 16,
    localparam int ACC_W = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [ACC_W-1:0] acc_in,
    output logic [ACC_W-1:0] acc
);
    // Total register: clear wins over load
    always_ff @(posedge clk) begin
        if (!rst_n || clear) acc <= '0;
        else if (load)       acc <= acc_in;
    end
endmodule

// File: rtl/sg_walker.sv
// Scatter-gather segment walker top. Emits the segment list of one parcel,
// either directly from the pointer or by walking chained 64-bit link tables.
// Assumes one read response per accepted request, returned in order.
module sg_walker #(
    parameter int ADDR_W = 36,
    parameter int LEN_W  = 16,
    localparam int ACC_W  = LEN_W + 1,
    localparam int STRIDE = sg_pkg::ENTRY_W / 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [ADDR_W-1:0]          ptr_addr,
    input  logic                       ptr_indirect,
    input  logic [LEN_W-1:0]           parcel_len,
    input  logic                       scatter_mode,
    output logic                       rd_req_valid,
    input  logic                       rd_req_ready,
    output logic [ADDR_W-1:0]          rd_req_addr,
    input  logic                       rd_rsp_valid,
    input  logic [sg_pkg::ENTRY_W-1:0] rd_rsp_data,
    output logic                       seg_valid,
    input  logic                       seg_ready,
    output logic [ADDR_W-1:0]          seg_addr,
    output logic [LEN_W-1:0]           seg_len,
    output logic                       seg_last,
    output logic                       done,
    output logic [2:0]                 err_code,
    output logic                       gather_err,
    output logic                       scatter_err
);
    import sg_pkg::*;

    sg_state_e        state;
    logic [ADDR_W-1:0] fetch_addr;
    logic [ADDR_W-1:0] seg_addr_q;
    logic [LEN_W-1:0]  seg_len_q;
    logic              seg_last_q;
    logic [LEN_W-1:0]  plen_q;
    logic              mode_q;
    sg_err_e           err_q;

    logic [ACC_W-1:0]  acc, acc_next;
    logic [ADDR_W-1:0] ent_addr;
    logic [LEN_W-1:0]  ent_len;
    logic              ent_final, ent_cont;
    sg_err_e           ent_err;
    logic              rsp_take, acc_load, walk_clear;

    sg_entry_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dec (
        .entry(rd_rsp_data), .acc(acc), .plen(plen_q),
        .ent_addr(ent_addr), .ent_len(ent_len), .ent_final(ent_final),
        .ent_cont(ent_cont), .acc_next(acc_next), .ent_err(ent_err)
    );

    sg_len_accum #(.LEN_W(LEN_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(walk_clear), .load(acc_load),
        .acc_in(acc_next), .acc(acc)
    );

    // Handshake qualifiers shared by the FSM and the accumulator
    always_comb begin
        walk_clear = (state == ST_IDLE) && start;
        rsp_take   = (state == ST_WAIT) && rd_rsp_valid;
        acc_load   = rsp_take && (ent_err == ERR_NONE) && !ent_cont;
    end

    // Walk sequencer: fetch, classify, emit, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            fetch_addr <= '0;
            seg_addr_q <= '0;
            seg_len_q  <= '0;
            seg_last_q <= 1'b0;
            plen_q     <= '0;
            mode_q     <= 1'b0;
            err_q      <= ERR_NONE;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    plen_q <= parcel_len;
                    mode_q <= scatter_mode;
                    err_q  <= ERR_NONE;
                    if (ptr_indirect) begin
                        fetch_addr <= ptr_addr;
                        state      <= ST_REQ;
                    end else if (parcel_len == '0) begin
                        err_q <= ERR_ZERO_LEN;
                        state <= ST_DONE;
                    end else begin
                        seg_addr_q <= ptr_addr;
                        seg_len_q  <= parcel_len;
                        seg_last_q <= 1'b1;
                        state      <= ST_EMIT;
                    end
                end
                ST_REQ: if (rd_req_ready) state <= ST_WAIT;
                ST_WAIT: if (rsp_take) begin
                    if (ent_err != ERR_NONE) begin
                        err_q <= ent_err;
                        state <= ST_DONE;
                    end else if (ent_cont) begin
                        fetch_addr <= ent_addr;
                        state      <= ST_REQ;
                    end else begin
                        seg_addr_q <= ent_addr;
                        seg_len_q  <= ent_len;
                        seg_last_q <= ent_final;
                        fetch_addr <= fetch_addr + ADDR_W'(STRIDE);
                        state      <= ST_EMIT;
                    end
                end
                ST_EMIT: if (seg_ready) state <= seg_last_q ? ST_DONE : ST_REQ;
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port mapping of the sequencer state
    always_comb begin
        rd_req_valid = (state == ST_REQ);
        rd_req_addr  = fetch_addr;
        seg_valid    = (state == ST_EMIT);
        seg_addr     = seg_addr_q;
        seg_len      = seg_len_q;
        seg_last     = seg_last_q;
        done         = (state == ST_DONE);
        err_code     = err_q;
        gather_err   = done && (err_q != ERR_NONE) && !mode_q;
        scatter_err  = done && (err_q != ERR_NONE) && mode_q;
    end

    // R10
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len) && $stable(seg_last));
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));
    // R11
    err_flag_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gather_err, scatter_err}));
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    total_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> acc <= ACC_W'(plen_q));
    // R8
    last_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && seg_last && (acc != '0) |-> acc == ACC_W'(plen_q));
endmodule

// File: tb/sg_walker_test.sv
module sg_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [35:0] ptr_addr = '0;
    logic        ptr_indirect = 1'b0;
    logic [15:0] parcel_len = '0;
    logic        scatter_mode = 1'b0;
    logic        rd_req_valid;
    logic        rd_req_ready = 1'b1;
    logic [35:0] rd_req_addr;
    logic        rd_rsp_valid = 1'b0;
    logic [63:0] rd_rsp_data = '0;
    logic        seg_valid;
    logic        seg_ready = 1'b1;
    logic [35:0] seg_addr;
    logic [15:0] seg_len;
    logic        seg_last;
    logic        done;
    logic [2:0]  err_code;
    logic        gather_err, scatter_err;

    always #2.5 clk = ~clk;

    sg_walker uut (.*);

    int n_chk = 0, n_bad = 0;
    bit summary_done = 0;

    logic [63:0] mem [0:255];
    logic        pend = 0;
    logic [35:0] pend_addr = '0;

    logic [35:0] sa [0:15];
    logic [15:0] sl [0:15];
    logic        sx [0:15];
    int          nseg = 0;
    logic [35:0] ra [0:15];
    int          nrd = 0;
    int          ndone = 0;
    logic [2:0]  last_err = '0;
    logic        last_g = 0, last_s = 0;

    // Memory model and monitors, away from the active edge
    always @(negedge clk) begin
        rd_rsp_valid = 1'b0;
        if (pend) begin
            rd_rsp_valid = 1'b1;
            rd_rsp_data  = mem[pend_addr[10:3]];
        end
        pend      = rd_req_valid && rd_req_ready;
        pend_addr = rd_req_addr;
        if (rd_req_valid && rd_req_ready && nrd < 16) begin ra[nrd] = rd_req_addr; nrd++; end
        if (seg_valid && seg_ready && nseg < 16) begin
            sa[nseg] = seg_addr; sl[nseg] = seg_len; sx[nseg] = seg_last; nseg++;
        end
        if (done) begin ndone++; last_err = err_code; last_g = gather_err; last_s = scatter_err; end
    end

    function automatic logic [63:0] ent(input logic [15:0] len, input logic ret,
                                        input logic cont, input logic [35:0] a);
        return {len, 6'b0, ret, cont, 4'b0, a};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
    endtask

    task automatic walk(input logic [35:0] a, input logic ind, input logic [15:0] len, input logic sm);
        @(negedge clk);
        nseg = 0; nrd = 0; ndone = 0;
        ptr_addr = a; ptr_indirect = ind; parcel_len = len; scatter_mode = sm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 400 && ndone == 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(ndone == 1, "R11 one done per walk", ndone, 1);
    endtask

    task automatic t_reset();
        chk(!seg_valid && !rd_req_valid && !done && !gather_err && !scatter_err,
            "R1 reset outputs", {seg_valid, rd_req_valid, done, gather_err, scatter_err}, 0);
    endtask

    task automatic t_direct();
        walk(36'h9_1234_5678, 1'b0, 16'd100, 1'b0);
        chk(nseg == 1, "R2 direct seg count", nseg, 1);
        chk(sa[0] == 36'h9_1234_5678, "R2 direct addr", sa[0], 36'h9_1234_5678);
        chk(sl[0] == 16'd100 && sx[0], "R2 direct len/last", {sl[0], sx[0]}, {16'd100, 1'b1});
        chk(nrd == 0, "R2 no reads", nrd, 0);
        chk(last_err == 0 && !last_g && !last_s, "R11 clean walk flags", {last_err, last_g, last_s}, 0);
        walk(36'h100, 1'b0, 16'd0, 1'b0);
        chk(nseg == 0 && last_err == 1, "R2 direct zero parcel", {nseg[7:0], last_err}, {8'd0, 3'd1});
    endtask

    task automatic t_single_table();
        mem[32] = ent(16'd10, 0, 0, 36'hA_0000_0000);
        mem[33] = ent(16'd20, 0, 0, 36'hA_0000_1000);
        mem[34] = ent(16'd30, 1, 0, 36'hA_0000_2000);
        walk(36'h100, 1'b1, 16'd60, 1'b0);
        chk(nrd == 3 && ra[0] == 36'h100, "R3 first read", ra[0], 36'h100);
        chk(ra[1] == 36'h108 && ra[2] == 36'h110, "R3 stride 8", {ra[1], ra[2]}, {36'h108, 36'h110});
        chk(nseg == 3, "R4 seg count", nseg, 3);
        chk(sa[1] == 36'hA_0000_1000 && sl[1] == 16'd20 && !sx[1], "R4 middle seg", {sa[1], sl[1]}, {36'hA_0000_1000, 16'd20});
        chk(sl[2] == 16'd30 && sx[2] && !sx[0], "R4 last flag", {sx[0], sx[2]}, 2'b01);
        chk(last_err == 0, "R4 clean", last_err, 0);
    endtask

    task automatic t_chain();
        mem[64]  = ent(16'd5, 0, 0, 36'hB_0000_0000);
        mem[65]  = ent(16'd0, 1, 1, 36'h400);
        mem[128] = ent(16'd7, 1, 0, 36'hB_0000_0100);
        walk(36'h200, 1'b1, 16'd12, 1'b1);
        chk(nrd == 3 && ra[2] == 36'h400, "R5 jump to next table", ra[2], 36'h400);
        chk(nseg == 2 && sa[1] == 36'hB_0000_0100 && sl[1] == 16'd7 && sx[1],
            "R5 chained seg", {sa[1], sl[1]}, {36'hB_0000_0100, 16'd7});
        chk(last_err == 0 && !last_s, "R5 ret bit on continuation ignored", last_err, 0);
    endtask

    task automatic t_zero_len();
        mem[96] = ent(16'd8, 0, 0, 36'hC_0000_0000);
        mem[97] = ent(16'd0, 0, 0, 36'hC_0000_0100);
        walk(36'h300, 1'b1, 16'd20, 1'b0);
        chk(last_err == 1 && nseg == 1, "R6 zero length", {nseg[7:0], last_err}, {8'd1, 3'd1});
        chk(last_g && !last_s, "R11 gather flag", {last_g, last_s}, 2'b10);
    endtask

    task automatic t_cont_len();
        mem[160] = ent(16'd4, 0, 1, 36'h600);
        walk(36'h500, 1'b1, 16'd20, 1'b1);
        chk(last_err == 2 && nrd == 1 && nseg == 0, "R7 nonzero continuation", {nrd[7:0], last_err}, {8'd1, 3'd2});
        chk(!last_g && last_s, "R11 scatter flag", {last_g, last_s}, 2'b01);
    endtask

    task automatic t_mismatch();
        mem[192] = ent(16'd10, 0, 0, 36'hD_0000_0000);
        mem[193] = ent(16'd20, 1, 0, 36'hD_0000_1000);
        walk(36'h600, 1'b1, 16'd40, 1'b0);
        chk(last_err == 3 && nseg == 1, "R8 short final", {nseg[7:0], last_err}, {8'd1, 3'd3});
    endtask

    task automatic t_overrun();
        mem[16] = ent(16'd30, 0, 0, 36'hE_0000_0000);
        mem[17] = ent(16'd20, 0, 0, 36'hE_0000_1000);
        mem[18] = ent(16'd1, 1, 0, 36'hE_0000_2000);
        walk(36'h080, 1'b1, 16'd40, 1'b1);
        chk(last_err == 4 && nseg == 1 && nrd == 2, "R9 overrun stops", {nrd[7:0], nseg[7:0], last_err}, {8'd2, 8'd1, 3'd4});
    endtask

    task automatic t_backpressure();
        logic [35:0] a0;
        logic [15:0] l0;
        @(negedge clk);
        seg_ready = 1'b0; nseg = 0; ndone = 0;
        ptr_addr = 36'h7_7777_0000; ptr_indirect = 1'b0; parcel_len = 16'd33; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        a0 = seg_addr; l0 = seg_len;
        repeat (4) @(negedge clk);
        chk(seg_valid && seg_addr == a0 && seg_len == l0 && l0 == 16'd33, "R10 hold under stall",
            {seg_valid, seg_len}, {1'b1, 16'd33});
        chk(ndone == 0, "R10 no done while stalled", ndone, 0);
        seg_ready = 1'b1;
        for (int i = 0; i < 20 && ndone == 0; i++) @(negedge clk);
        chk(nseg == 1 && ndone == 1, "R10 release", {nseg[7:0], ndone[7:0]}, 16'h0101);
        rd_req_ready = 1'b0;
        ndone = 0;
        ptr_addr = 36'h100; ptr_indirect = 1'b1; parcel_len = 16'd60; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        chk(rd_req_valid && rd_req_addr == 36'h100, "R10 read request held", rd_req_addr, 36'h100);
        rd_req_ready = 1'b1;
        for (int i = 0; i < 100 && ndone == 0; i++) @(negedge clk);
        chk(last_err == 0, "R10 stalled walk completes", last_err, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_direct();
        t_single_table();
        t_chain();
        t_zero_len();
        t_cont_len();
        t_mismatch();
        t_overrun();
        t_backpressure();
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end
endmodule